// File: doc/BRIEF.md
# Flash write status readout logic

This block sits between the array read path and the data bus of a flash device. While an internal program or erase runs, it substitutes a status byte for the array data. Bit 7 carries a data-complement poll and bit 6 carries a flip-flop that alternates on every status read. Software tells that a write has finished when the polled bit shows true data and bit 6 stops alternating.

When busy falls, a settling window opens for a parameterised number of array reads. During these reads only bit 7 carries true data and the lower bits read zero. Register accesses and out-of-range reads are kept away from the status path while the device is busy. Every read is answered one clock after its strobe on a registered output.

Top module: `wstat_readout`

## Requirements
- R1: A status read during a program (busy high, `op_erase_i`=0 captured on the rising edge of busy) returns bit 7 as the inverse of bit 7 of `wr_byte_i` captured on that edge, and bits 5:0 as zero.
- R2: A status read during an erase (`op_erase_i`=1 captured on the rising edge of busy) returns bit 7 as 0 and bits 5:0 as zero.
- R3: The first status read after busy rises returns bit 6 as 0. Each later status read in the same busy period returns bit 6 inverted from the previous status read.
- R4: Only status reads advance the bit 6 flip-flop. Idle clocks, register reads and out-of-range reads leave the next status bit 6 unchanged.
- R5: After busy falls, the first SETTLE_READS in-range array reads return bits 6:0 as zero. Bit 7 is the captured bit 7 of the written byte after a program, and 1 after an erase.
- R6: An in-range array read outside busy and outside the settling window returns `arr_data_i`.
- R7: A register read (`reg_sel_i`=1) returns 0x00 while busy and `reg_data_i` otherwise.
- R8: `reg_wr_en_o` equals `reg_wr_i` when busy is low and is 0 while busy is high, in the same cycle.
- R9: An out-of-range read (`addr_ok_i`=0) while busy returns 0xFF. When idle it returns `arr_data_i`. It never consumes a settling read.
- R10: `rd_vld_o` pulses in the cycle after each `rd_stb_i`. `rd_data_o` changes only in that cycle and holds otherwise. Both are 0 after reset.
- R11: A new rising edge of busy during the settling window ends the window, and status reporting restarts at R1/R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Internal program or erase in progress |
| op_erase_i | input | 1 | Operation type sampled when busy rises: 1 erase, 0 program |
| wr_byte_i | input | DATA_W | Byte being programmed, sampled when busy rises |
| arr_data_i | input | DATA_W | Array read data |
| rd_stb_i | input | 1 | Read strobe, one cycle per read |
| addr_ok_i | input | 1 | Read address lies in the valid range |
| reg_sel_i | input | 1 | Access targets a register instead of the array |
| reg_data_i | input | DATA_W | Register read data |
| reg_wr_i | input | 1 | Register write request |
| reg_wr_en_o | output | 1 | Register write allowed |
| rd_data_o | output | DATA_W | Byte returned on the data bus |
| rd_vld_o | output | 1 | Read data valid |

## Verification
Every read result is due exactly one clock after its strobe, and the write gate responds in the same cycle as its request. Busy edges act on a read issued in the edge cycle itself, so a read on the first busy cycle already reports status and a read on the first idle cycle is the first settling read. The bench drives inputs shortly after the falling edge. Its reference model advances on the rising edge and computes each expected byte for the cycle after the strobe. Outputs are compared on every falling edge against that expectation, so the one-cycle latency is checked in every clock and never assumed.

// File: rtl/wstat_pkg.sv
package wstat_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_REG,
    RK_REG_BLOCK,
    RK_OOR_BUSY,
    RK_STATUS,
    RK_SETTLE,
    RK_ARRAY
  } rd_kind_e;

  typedef struct packed {
    logic erase;
    logic wb_msb;
  } op_ctx_t;

endpackage

// File: rtl/wstat_op_track.sv
module wstat_op_track
  import wstat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    busy_i,
  input  logic    op_erase_i,
  input  logic    wr_msb_i,
  output logic    start_o,
  output logic    done_o,
  output op_ctx_t ctx_o
);

  logic    busy_q;
  op_ctx_t ctx_q;
  op_ctx_t ctx_d;

  always_comb begin
    start_o = busy_i & ~busy_q;
    done_o  = ~busy_i & busy_q;
    ctx_d   = ctx_q;
    if (start_o) begin
      ctx_d.erase  = op_erase_i;
      ctx_d.wb_msb = wr_msb_i;
    end
    ctx_o = ctx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ctx_q  <= '0;
    end else begin
      busy_q <= busy_i;
      if (start_o) ctx_q <= ctx_d;
    end
  end

endmodule

// File: rtl/wstat_classify.sv
module wstat_classify
  import wstat_pkg::*;
(
  input  logic     rd_stb_i,
  input  logic     busy_i,
  input  logic     addr_ok_i,
  input  logic     reg_sel_i,
  input  logic     settle_act_i,
  output rd_kind_e kind_o
);

  always_comb begin
    kind_o = RK_NONE;
    if (rd_stb_i) begin
      if (reg_sel_i)         kind_o = busy_i ? RK_REG_BLOCK : RK_REG;
      else if (!addr_ok_i)   kind_o = busy_i ? RK_OOR_BUSY : RK_ARRAY;
      else if (busy_i)       kind_o = RK_STATUS;
      else if (settle_act_i) kind_o = RK_SETTLE;
      else                   kind_o = RK_ARRAY;
    end
  end

endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic adv_i,
  output logic tog_o
);

  logic tog_q;
  logic tog_d;
  logic tog_en;

  always_comb begin
    tog_o  = start_i ? 1'b0 : tog_q;
    tog_d  = adv_i ? ~tog_o : tog_o;
    tog_en = start_i | adv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

endmodule

// File: rtl/wstat_settle.sv
module wstat_settle #(
  parameter int SETTLE_READS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  input  logic use_i,
  output logic active_o
);

  localparam int CNT_W = (SETTLE_READS < 1) ? 1 : $clog2(SETTLE_READS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_READS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_eff;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    if (start_i)     cnt_eff = '0;
    else if (done_i) cnt_eff = LOAD;
    else             cnt_eff = cnt_q;
    active_o = (cnt_eff != '0);
    cnt_d    = (use_i && active_o) ? cnt_eff - 1'b1 : cnt_eff;
    cnt_en   = start_i | done_i | use_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wstat_outreg.sv
module wstat_outreg
  import wstat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_kind_e          kind_i,
  input  op_ctx_t           ctx_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic [DATA_W-1:0] reg_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);

  localparam int LOW_W = DATA_W - 2;

  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] data_q;
  logic              vld_q;
  logic              ld_en;
  logic              poll_busy;
  logic              poll_done;

  always_comb begin
    poll_busy = ctx_i.erase ? 1'b0 : ~ctx_i.wb_msb;
    poll_done = ctx_i.erase ? 1'b1 : ctx_i.wb_msb;
    ld_en     = (kind_i != RK_NONE);
    unique case (kind_i)
      RK_REG:       data_d = reg_data_i;
      RK_REG_BLOCK: data_d = '0;
      RK_OOR_BUSY:  data_d = '1;
      RK_STATUS:    data_d = {poll_busy, tog_i, {LOW_W{1'b0}}};
      RK_SETTLE:    data_d = {poll_done, 1'b0, {LOW_W{1'b0}}};
      RK_ARRAY:     data_d = arr_data_i;
      default:      data_d = data_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= ld_en;
      if (ld_en) data_q <= data_d;
    end
  end

  assign rd_data_o = data_q;
  assign rd_vld_o  = vld_q;

endmodule

// File: rtl/wstat_readout.sv
module wstat_readout
  import wstat_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SETTLE_READS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              op_erase_i,
  input  logic [DATA_W-1:0] wr_byte_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              rd_stb_i,
  input  logic              addr_ok_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic              reg_wr_i,
  output logic              reg_wr_en_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);

  localparam int POLL_BIT = DATA_W - 1;

  logic     start;
  logic     done;
  op_ctx_t  ctx;
  rd_kind_e kind;
  logic     settle_act;
  logic     tog;

  wstat_op_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy_i),
    .op_erase_i (op_erase_i),
    .wr_msb_i   (wr_byte_i[POLL_BIT]),
    .start_o    (start),
    .done_o     (done),
    .ctx_o      (ctx)
  );

  wstat_settle #(.SETTLE_READS(SETTLE_READS)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .done_i   (done),
    .use_i    (kind == RK_SETTLE),
    .active_o (settle_act)
  );

  wstat_classify u_cls (
    .rd_stb_i     (rd_stb_i),
    .busy_i       (busy_i),
    .addr_ok_i    (addr_ok_i),
    .reg_sel_i    (reg_sel_i),
    .settle_act_i (settle_act),
    .kind_o       (kind)
  );

  wstat_toggle u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .adv_i   (kind == RK_STATUS),
    .tog_o   (tog)
  );

  wstat_outreg #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind_i     (kind),
    .ctx_i      (ctx),
    .tog_i      (tog),
    .arr_data_i (arr_data_i),
    .reg_data_i (reg_data_i),
    .rd_data_o  (rd_data_o),
    .rd_vld_o   (rd_vld_o)
  );

  assign reg_wr_en_o = reg_wr_i & ~busy_i;

endmodule

// File: rtl/wstat_readout_chk.sv
module wstat_readout_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              rd_stb_i,
  input logic              addr_ok_i,
  input logic              reg_sel_i,
  input logic              reg_wr_i,
  input logic              reg_wr_en_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_vld_o
);

  localparam int TOG = DATA_W - 2;

  logic busy_prev;
  logic par_q;
  logic par_eff;
  logic st_rd;

  assign st_rd   = rd_stb_i && busy_i && addr_ok_i && !reg_sel_i;
  assign par_eff = (busy_i && !busy_prev) ? 1'b0 : par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_prev <= 1'b0;
      par_q     <= 1'b0;
    end else begin
      busy_prev <= busy_i;
      par_q     <= st_rd ? ~par_eff : par_eff;
    end
  end

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> (rd_data_o[TOG-1:0] == '0)); // R1
  AST_TOGGLE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> (rd_data_o[TOG] == $past(par_eff))); // R3
  AST_REG_WR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !reg_wr_en_o); // R8
  AST_REG_RD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && reg_sel_i && busy_i) |=> (rd_data_o == '0)); // R7
  AST_OOR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !reg_sel_i && !addr_ok_i && busy_i) |=> (rd_data_o == '1)); // R9
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> rd_vld_o); // R10
  AST_NO_SPUR_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> (!rd_vld_o && $stable(rd_data_o))); // R10

endmodule

bind wstat_readout wstat_readout_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_i      (busy_i),
  .rd_stb_i    (rd_stb_i),
  .addr_ok_i   (addr_ok_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wr_en_o (reg_wr_en_o),
  .rd_data_o   (rd_data_o),
  .rd_vld_o    (rd_vld_o)
);

// File: tb/sim_wstat_readout.sv
`timescale 1ns/1ps
module sim_wstat_readout;

  localparam int DW     = 8;
  localparam int SETTLE = 2;

  logic          clk;
  logic          rst_n;
  logic          busy;
  logic          op_erase;
  logic [DW-1:0] wr_byte;
  logic [DW-1:0] arr_data;
  logic          rd_stb;
  logic          addr_ok;
  logic          reg_sel;
  logic [DW-1:0] reg_data;
  logic          reg_wr;
  logic          reg_wr_en;
  logic [DW-1:0] rd_data;
  logic          rd_vld;

  int compared = 0;
  int mismatched = 0;
  bit done_flag = 0;

  wstat_readout #(.DATA_W(DW), .SETTLE_READS(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_erase_i(op_erase),
    .wr_byte_i(wr_byte), .arr_data_i(arr_data), .rd_stb_i(rd_stb),
    .addr_ok_i(addr_ok), .reg_sel_i(reg_sel), .reg_data_i(reg_data),
    .reg_wr_i(reg_wr), .reg_wr_en_o(reg_wr_en), .rd_data_o(rd_data),
    .rd_vld_o(rd_vld)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // reference model state
  bit      m_busy_prev;
  bit      m_erase;
  bit      m_wb7;
  bit      m_tog;
  int      m_settle;
  int      exp_data;
  bit      exp_vld;
  string   exp_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy_prev = 0; m_erase = 0; m_wb7 = 0; m_tog = 0; m_settle = 0;
      exp_data = 0; exp_vld = 0; exp_tag = "R10";
    end else begin
      bit start, fin;
      start = busy && !m_busy_prev;
      fin   = !busy && m_busy_prev;
      if (start) begin
        m_erase = op_erase; m_wb7 = wr_byte[7]; m_tog = 0; m_settle = 0;
      end
      if (fin) m_settle = SETTLE;
      exp_vld = rd_stb;
      if (!rd_stb) exp_tag = "R10";
      else if (reg_sel) begin
        exp_data = busy ? 0 : int'(reg_data); exp_tag = "R7";
      end else if (!addr_ok) begin
        exp_data = busy ? 8'hFF : int'(arr_data); exp_tag = "R9";
      end else if (busy) begin
        exp_data = (m_erase ? 0 : (m_wb7 ? 0 : 128)) + (m_tog ? 64 : 0);
        exp_tag = m_erase ? "R2/R3" : "R1/R3";
        m_tog = !m_tog;
      end else if (m_settle > 0) begin
        exp_data = (m_erase || m_wb7) ? 128 : 0;
        exp_tag = "R5";
        m_settle--;
      end else begin
        exp_data = int'(arr_data); exp_tag = "R6";
      end
      m_busy_prev = busy;
    end
  end

  always @(negedge clk) begin
    if (!done_flag) begin
      compared++;
      if (int'(rd_data) != exp_data || rd_vld != exp_vld) begin
        mismatched++;
        $display("FAIL %s: data=%02h vld=%0b expected data=%02h vld=%0b at %0t",
                 exp_tag, rd_data, rd_vld, exp_data[7:0], exp_vld, $time);
      end
      compared++;
      if (reg_wr_en != (reg_wr && !busy)) begin
        mismatched++;
        $display("FAIL R8: reg_wr_en=%0b expected %0b", reg_wr_en, reg_wr && !busy);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #0.5;
      rd_stb = 0; reg_wr = 0;
    end
  endtask

  task automatic rd(bit sel, bit ok, logic [7:0] arr);
    @(negedge clk); #0.5;
    rd_stb = 1; reg_sel = sel; addr_ok = ok; arr_data = arr; reg_wr = 0;
  endtask

  task automatic set_busy(bit b, bit er, logic [7:0] wb);
    @(negedge clk); #0.5;
    rd_stb = 0; busy = b; op_erase = er; wr_byte = wb;
  endtask

  initial begin
    rst_n = 0; busy = 0; op_erase = 0; wr_byte = 0; arr_data = 0;
    rd_stb = 0; addr_ok = 1; reg_sel = 0; reg_data = 8'h15; reg_wr = 0;
    repeat (3) @(negedge clk);   // R10 reset values compared here
    #0.5 rst_n = 1;
    // R6 idle array reads, R7 idle register read, R9 idle out-of-range
    rd(0, 1, 8'h3C); rd(0, 1, 8'hA5); rd(1, 1, 8'h00); rd(0, 0, 8'h77); tick(2);
    // R8 register write when idle
    @(negedge clk); #0.5 reg_wr = 1; tick();
    // program, written byte MSB=1 -> R1 poll 0 ; R3 toggling ; R4 gaps
    set_busy(1, 0, 8'h9E);
    rd(0, 1, 8'h00); rd(0, 1, 8'h00); tick(3); rd(0, 1, 8'h00);
    rd(1, 1, 8'h00);   // R7 blocked, R4 no advance
    rd(0, 0, 8'h11);   // R9 0xFF, R4 no advance
    rd(0, 1, 8'h00);
    @(negedge clk); #0.5 reg_wr = 1; rd_stb = 0; tick();   // R8 blocked
    // busy falls with read in same cycle -> R5 window
    @(negedge clk); #0.5 busy = 0; rd_stb = 1; reg_sel = 0; addr_ok = 1; arr_data = 8'h9E;
    rd(0, 0, 8'h44);   // out-of-range does not consume window (R9)
    rd(0, 1, 8'h9E); rd(0, 1, 8'h9E); rd(0, 1, 8'h9E); tick();  // R6 after window
    // erase: R2 poll 0, window bit7=1
    set_busy(1, 1, 8'h00);
    rd(0, 1, 8'h00); rd(0, 1, 8'h00); rd(0, 1, 8'h00); tick(2);
    set_busy(0, 1, 8'h00);
    rd(0, 1, 8'hFF); rd(0, 1, 8'hFF); rd(0, 1, 8'hFF); tick();
    // program with MSB=0, then R11: restart during window
    set_busy(1, 0, 8'h42); rd(0, 1, 8'h00); rd(0, 1, 8'h00);
    set_busy(0, 0, 8'h42); rd(0, 1, 8'h42);
    set_busy(1, 1, 8'h00); rd(0, 1, 8'h00); rd(0, 1, 8'h00);
    set_busy(0, 1, 8'h00); rd(0, 1, 8'hFF); rd(0, 1, 8'hFF); rd(0, 1, 8'hFF);
    // read in the very cycle busy rises (R3 first read bit6=0)
    @(negedge clk); #0.5 busy = 1; op_erase = 0; wr_byte = 8'h01; rd_stb = 1;
    rd(0, 1, 8'h00); tick(2);
    set_busy(0, 0, 8'h01); tick(4); rd(0, 1, 8'h01); rd(0, 1, 8'h01); rd(0, 1, 8'h5A);
    tick(3);
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #20000;
    if (!done_flag) begin
      done_flag = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule